// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides which of two power switches feeds the output rail: the path from the main supply or the path from a backup battery. It works purely on digital flags that analog comparators elsewhere produce: whether the main supply is above the battery, whether the output rail has sagged below the negative switch threshold, and whether the main supply has climbed above the positive switch threshold. A manual input lets firmware or a strap force the rail onto the battery while it is running from the main supply. The switch enables are driven from a state machine. It never turns both on together, and every handover passes through a fixed number of cycles in which both are off.

Entry into battery mode and exit from it use different conditions. The battery is taken only once the rail has actually sagged and the battery is the higher source. A battery above a healthy main supply is therefore left alone. Return to main waits until the main supply is above the battery or above the positive threshold. A shelf-seal state keeps the battery path open for storage. It is armed by a pin pattern (power-fail output held low, power-fail input high, main supply good, manual reset held low) followed by loss of the main supply. It is cleared by the first rising edge of the supervisor reset after the main supply returns. A seal bit retained outside the block can be loaded at reset.

States: `ST_MAIN` (main path on), `ST_GAP_TO_BAT` (both off, heading to battery), `ST_BAT` (battery path on), `ST_GAP_TO_MAIN` (both off, heading to main). Transitions: MAIN→GAP_TO_BAT on a battery request; GAP_TO_BAT→BAT when the gap timer expires; BAT→GAP_TO_MAIN on a return request or when the seal engages; GAP_TO_MAIN→MAIN when the gap timer expires. The seal flag is held in its own register beside the state machine.

Top module: `bkup_sw_ctrl`

## Requirements
- R1: After `rst_n` is released with `seal_keep` low, `main_sw_en`=1, `bat_sw_en`=0 and `mode`=0 (main).
- R2: In main mode and not sealed, `out_lt_swn`=1 together with `main_gt_bat`=0 starts a handover to the battery, which ends with `bat_sw_en`=1 and `mode`=1.
- R3: In main mode the rail stays on main while the battery is higher but `out_lt_swn`=0, and also while `out_lt_swn`=1 but `main_gt_bat`=1.
- R4: In battery mode with `force_bat` low, the rail returns to main when `main_gt_bat`=1 or `main_gt_swp`=1. Recovery of the output alone (`out_lt_swn`=0) does not end battery mode.
- R5: `force_bat`=1 in main mode starts a handover to the battery. While it stays high in battery mode, the battery is kept even if the return conditions hold.
- R6: `main_sw_en` and `bat_sw_en` are never 1 together. Each handover shows `GAP_CYCLES` cycles with both off and `mode`=2 (gap).
- R7: If power-fail output low, power-fail input high, `main_ok`=1 and manual reset low all hold in one cycle and `main_ok` is 0 in the next, the seal engages. On main it is reported as `mode`=3 with `main_sw_en`=1.
- R8: While sealed, `bat_sw_en` stays 0 whatever `force_bat`, `out_lt_swn` and `main_gt_bat` do. A seal that engages in battery mode drops the battery path at once and returns to main through a gap.
- R9: A rising edge of `sup_reset_n` while `main_ok`=1 clears the seal, so `mode` goes from 3 to 0.
- R10: With `seal_keep`=1 during reset, the block comes out of reset sealed (`mode`=3).
- R11: If any one of the seal preconditions is missing when `main_ok` falls, the seal does not engage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| seal_keep | input | 1 | Retained seal bit, loaded into the seal flag during reset |
| main_gt_bat | input | 1 | Main supply is above the battery |
| out_lt_swn | input | 1 | Output rail is below the negative switch threshold |
| main_gt_swp | input | 1 | Main supply is above the positive switch threshold |
| force_bat | input | 1 | Manual request to run from the battery (tie low if unused) |
| sup_reset_n | input | 1 | Supervisor reset output, active low; its rising edge clears the seal |
| pwrfail_out_low | input | 1 | Power-fail output pin is held low |
| pwrfail_in_high | input | 1 | Power-fail input is above its threshold |
| main_ok | input | 1 | Main supply is above the reset threshold |
| manrst_low | input | 1 | Manual reset pin is held low |
| main_sw_en | output | 1 | Enable of the main-to-rail switch |
| bat_sw_en | output | 1 | Enable of the battery-to-rail switch |
| mode | output | 2 | 0 main, 1 battery, 2 gap, 3 sealed on main |

## Verification
Sag patterns where only one of the two entry flags is set separate the AND in the entry rule from a looser OR. Holding battery mode while only the output recovers, then releasing it through each of the two exit flags in turn, shows that the exit rule is not simply the inverse of the entry rule. Forcing the battery with the exit conditions already true shows that the manual input holds the battery once it is selected. The seal is armed once with the full pin pattern and once with the manual reset missing, and it is also engaged from battery mode. Each gap is sampled cycle by cycle so that a gap that is too short or missing shows up.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

    typedef enum logic [1:0] {
        ST_MAIN        = 2'd0,
        ST_GAP_TO_BAT  = 2'd1,
        ST_BAT         = 2'd2,
        ST_GAP_TO_MAIN = 2'd3
    } sw_state_e;

    localparam logic [1:0] MODE_MAIN   = 2'd0;
    localparam logic [1:0] MODE_BAT    = 2'd1;
    localparam logic [1:0] MODE_GAP    = 2'd2;
    localparam logic [1:0] MODE_SEALED = 2'd3;

endpackage

// File: rtl/bkup_seal_tracker.sv
module bkup_seal_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic seal_keep,
    input  logic pwrfail_out_low,
    input  logic pwrfail_in_high,
    input  logic main_ok,
    input  logic manrst_low,
    input  logic sup_reset_n,
    output logic sealed
);

    logic ready_q;
    logic sup_prev_q;
    logic arm_now;
    logic clear_now;

    // the arming pattern must be seen with the main supply still good
    assign arm_now   = ready_q && !main_ok;
    // first rising edge of the supervisor reset once main is back
    assign clear_now = sup_reset_n && !sup_prev_q && main_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q    <= 1'b0;
            sup_prev_q <= 1'b1;
        end else begin
            ready_q    <= pwrfail_out_low && pwrfail_in_high && main_ok && manrst_low;
            sup_prev_q <= sup_reset_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sealed <= seal_keep;
        end else if (clear_now) begin
            sealed <= 1'b0;
        end else if (arm_now) begin
            sealed <= 1'b1;
        end
    end

endmodule

// File: rtl/bkup_gap_timer.sv
module bkup_gap_timer #(
    parameter int GAP_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int GAP_EFF = (GAP_CYCLES < 1) ? 1 : GAP_CYCLES;
    localparam int CW      = (GAP_EFF < 2) ? 1 : $clog2(GAP_EFF);
    localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_EFF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/bkup_sw_fsm.sv
module bkup_sw_fsm
    import bkup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_gt_bat,
    input  logic       out_lt_swn,
    input  logic       main_gt_swp,
    input  logic       force_bat,
    input  logic       sealed,
    input  logic       gap_done,
    output logic       gap_load,
    output logic       main_sw_en,
    output logic       bat_sw_en,
    output logic [1:0] mode
);

    sw_state_e state_q;
    sw_state_e state_d;
    logic      want_bat;
    logic      want_main;

    // entry: sag seen and battery is the higher source, or manual force
    assign want_bat  = !sealed && (force_bat || (out_lt_swn && !main_gt_bat));
    // exit: main above battery or above the upper threshold, unless forced
    assign want_main = sealed || (!force_bat && (main_gt_bat || main_gt_swp));

    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        unique case (state_q)
            ST_MAIN: begin
                if (want_bat) begin
                    state_d  = ST_GAP_TO_BAT;
                    gap_load = 1'b1;
                end
            end
            ST_GAP_TO_BAT: begin
                if (gap_done) state_d = ST_BAT;
            end
            ST_BAT: begin
                if (want_main) begin
                    state_d  = ST_GAP_TO_MAIN;
                    gap_load = 1'b1;
                end
            end
            ST_GAP_TO_MAIN: begin
                if (gap_done) state_d = ST_MAIN;
            end
            default: state_d = ST_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MAIN;
        else        state_q <= state_d;
    end

    always_comb begin
        main_sw_en = 1'b0;
        bat_sw_en  = 1'b0;
        mode       = MODE_GAP;
        unique case (state_q)
            ST_MAIN: begin
                main_sw_en = 1'b1;
                mode       = sealed ? MODE_SEALED : MODE_MAIN;
            end
            ST_BAT: begin
                bat_sw_en = !sealed;
                mode      = sealed ? MODE_GAP : MODE_BAT;
            end
            ST_GAP_TO_BAT, ST_GAP_TO_MAIN: begin
                mode = MODE_GAP;
            end
            default: mode = MODE_GAP;
        endcase
    end

endmodule

// File: rtl/bkup_sw_ctrl.sv
module bkup_sw_ctrl #(
    parameter int GAP_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seal_keep,
    input  logic       main_gt_bat,
    input  logic       out_lt_swn,
    input  logic       main_gt_swp,
    input  logic       force_bat,
    input  logic       sup_reset_n,
    input  logic       pwrfail_out_low,
    input  logic       pwrfail_in_high,
    input  logic       main_ok,
    input  logic       manrst_low,
    output logic       main_sw_en,
    output logic       bat_sw_en,
    output logic [1:0] mode
);

    logic sealed_w;
    logic gap_load_w;
    logic gap_done_w;

    bkup_seal_tracker u_seal (
        .clk             (clk),
        .rst_n           (rst_n),
        .seal_keep       (seal_keep),
        .pwrfail_out_low (pwrfail_out_low),
        .pwrfail_in_high (pwrfail_in_high),
        .main_ok         (main_ok),
        .manrst_low      (manrst_low),
        .sup_reset_n     (sup_reset_n),
        .sealed          (sealed_w)
    );

    bkup_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load_w),
        .done  (gap_done_w)
    );

    bkup_sw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_gt_bat (main_gt_bat),
        .out_lt_swn  (out_lt_swn),
        .main_gt_swp (main_gt_swp),
        .force_bat   (force_bat),
        .sealed      (sealed_w),
        .gap_done    (gap_done_w),
        .gap_load    (gap_load_w),
        .main_sw_en  (main_sw_en),
        .bat_sw_en   (bat_sw_en),
        .mode        (mode)
    );

endmodule

// File: rtl/bkup_sw_chk.sv
module bkup_sw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       main_gt_bat,
    input logic       out_lt_swn,
    input logic       main_gt_swp,
    input logic       force_bat,
    input logic       sup_reset_n,
    input logic       main_ok,
    input logic       main_sw_en,
    input logic       bat_sw_en,
    input logic [1:0] mode,
    input logic       sealed
);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_sw_en && bat_sw_en));

    // R6
    bat_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_sw_en) |-> $past(!main_sw_en));

    // R6
    main_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_sw_en) |-> $past(!bat_sw_en));

    // R2
    enter_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && out_lt_swn && !main_gt_bat) |=> (mode == 2'd2 && !main_sw_en && !bat_sw_en));

    // R3
    stay_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !force_bat && !(out_lt_swn && !main_gt_bat)) |=> main_sw_en);

    // R4
    hold_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !main_gt_bat && !main_gt_swp) |=> (bat_sw_en || sealed));

    // R5
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && force_bat) |=> (bat_sw_en || sealed));

    // R8
    sealed_no_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |-> !bat_sw_en);

    // R9
    seal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sup_reset_n) && main_ok) |=> !sealed);

endmodule

bind bkup_sw_ctrl bkup_sw_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_gt_bat (main_gt_bat),
    .out_lt_swn  (out_lt_swn),
    .main_gt_swp (main_gt_swp),
    .force_bat   (force_bat),
    .sup_reset_n (sup_reset_n),
    .main_ok     (main_ok),
    .main_sw_en  (main_sw_en),
    .bat_sw_en   (bat_sw_en),
    .mode        (mode),
    .sealed      (sealed_w)
);

// File: tb/bkup_sw_ctrl_bench.sv
module bkup_sw_ctrl_bench;

    localparam int GAP = 2;
    localparam logic [3:0] O_MAIN   = 4'b1000;
    localparam logic [3:0] O_BAT    = 4'b0101;
    localparam logic [3:0] O_GAP    = 4'b0010;
    localparam logic [3:0] O_SEALED = 4'b1011;

    logic clk = 1'b0;
    logic rst_n, seal_keep, main_gt_bat, out_lt_swn, main_gt_swp, force_bat;
    logic sup_reset_n, pwrfail_out_low, pwrfail_in_high, main_ok, manrst_low;
    logic main_sw_en, bat_sw_en;
    logic [1:0] mode;

    int checks = 0;
    int fails  = 0;
    logic overlap_seen = 1'b0;

    always #4 clk = ~clk;

    bkup_sw_ctrl #(.GAP_CYCLES(GAP)) u_bkup_sw_ctrl (
        .clk(clk), .rst_n(rst_n), .seal_keep(seal_keep),
        .main_gt_bat(main_gt_bat), .out_lt_swn(out_lt_swn), .main_gt_swp(main_gt_swp),
        .force_bat(force_bat), .sup_reset_n(sup_reset_n),
        .pwrfail_out_low(pwrfail_out_low), .pwrfail_in_high(pwrfail_in_high),
        .main_ok(main_ok), .manrst_low(manrst_low),
        .main_sw_en(main_sw_en), .bat_sw_en(bat_sw_en), .mode(mode)
    );

    always @(negedge clk) if (rst_n && main_sw_en && bat_sw_en) overlap_seen = 1'b1;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {main_sw_en, bat_sw_en, mode};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        main_gt_bat = 1'b1; out_lt_swn = 1'b0; main_gt_swp = 1'b1; force_bat = 1'b0;
        sup_reset_n = 1'b1; pwrfail_out_low = 1'b0; pwrfail_in_high = 1'b1;
        main_ok = 1'b1; manrst_low = 1'b0;
    endtask

    task automatic do_reset(input logic keep);
        idle_inputs();
        seal_keep = keep;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    // checks a full gap of GAP cycles followed by the target state
    task automatic walk_gap(input string req, input logic [3:0] target);
        for (int i = 0; i < GAP; i++) begin
            step(1);
            check(req, O_GAP);
        end
        step(1);
        check(req, target);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1", O_MAIN);
    endtask

    task automatic t_no_enter();
        main_gt_bat = 1'b0; out_lt_swn = 1'b0; main_gt_swp = 1'b0;
        step(4);
        check("R3", O_MAIN);
        main_gt_bat = 1'b1; out_lt_swn = 1'b1;
        step(4);
        check("R3", O_MAIN);
        idle_inputs();
        step(1);
    endtask

    task automatic t_enter_exit_swp();
        main_gt_bat = 1'b0; main_gt_swp = 1'b0; out_lt_swn = 1'b1;
        walk_gap("R2", O_BAT);
        out_lt_swn = 1'b0;
        step(4);
        check("R4", O_BAT);
        main_gt_swp = 1'b1;
        walk_gap("R4", O_MAIN);
        idle_inputs();
        step(1);
    endtask

    task automatic t_enter_exit_cross();
        main_gt_bat = 1'b0; main_gt_swp = 1'b0; out_lt_swn = 1'b1;
        walk_gap("R6", O_BAT);
        out_lt_swn = 1'b0; main_gt_bat = 1'b1;
        walk_gap("R4", O_MAIN);
        idle_inputs();
        step(1);
    endtask

    task automatic t_force();
        force_bat = 1'b1;
        walk_gap("R5", O_BAT);
        step(4);
        check("R5", O_BAT);
        force_bat = 1'b0;
        walk_gap("R5", O_MAIN);
    endtask

    task automatic t_seal_miss();
        pwrfail_out_low = 1'b1;
        step(2);
        main_ok = 1'b0;
        step(2);
        check("R11", O_MAIN);
        idle_inputs();
        step(2);
    endtask

    task automatic t_seal_arm_clear();
        pwrfail_out_low = 1'b1; manrst_low = 1'b1;
        step(2);
        main_ok = 1'b0;
        step(1);
        check("R7", O_SEALED);
        pwrfail_out_low = 1'b0; manrst_low = 1'b0;
        force_bat = 1'b1; out_lt_swn = 1'b1; main_gt_bat = 1'b0;
        step(5);
        check("R8", O_SEALED);
        idle_inputs();
        step(2);
        sup_reset_n = 1'b0;
        step(2);
        check("R9", O_SEALED);
        sup_reset_n = 1'b1;
        step(1);
        check("R9", O_MAIN);
    endtask

    task automatic t_seal_from_bat();
        force_bat = 1'b1;
        walk_gap("R5", O_BAT);
        pwrfail_out_low = 1'b1; manrst_low = 1'b1;
        step(2);
        main_ok = 1'b0;
        step(1);
        check("R8", O_GAP);
        walk_gap("R8", O_SEALED);
        idle_inputs();
        step(1);
        sup_reset_n = 1'b0;
        step(1);
        sup_reset_n = 1'b1;
        step(1);
        check("R9", O_MAIN);
    endtask

    task automatic t_seal_keep();
        do_reset(1'b1);
        check("R10", O_SEALED);
        force_bat = 1'b1;
        step(3);
        check("R10", O_SEALED);
        force_bat = 1'b0;
        sup_reset_n = 1'b0;
        step(1);
        sup_reset_n = 1'b1;
        step(1);
        check("R9", O_MAIN);
    endtask

    initial begin
        idle_inputs();
        seal_keep = 1'b0;
        rst_n = 1'b0;
        t_reset();
        t_no_enter();
        t_enter_exit_swp();
        t_enter_exit_cross();
        t_force();
        t_seal_miss();
        t_seal_arm_clear();
        t_seal_from_bat();
        t_seal_keep();
        checks++;
        if (overlap_seen) begin
            fails++;
            $display("FAIL R6: both switches on, got 1 expected 0");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule